// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Controller

This block decides, on request, whether the highest pending interrupt level is accepted by the processor, and carries out every register side effect of accepting it in one clock edge. It owns the processor status word, the per-level saved program counters and saved status words, the double-fault saved program counter, the exception-cause register, the vector-base register and the program-counter register that the fetch unit follows.

Levels 2 and above are vectored directly: the old program counter and status are saved in that level's slots, the status interrupt-level field is raised to the new level with the exception-mode bit set, and the program counter jumps to that level's vector. Level 1 is not vectored directly. It becomes one of three general exceptions chosen from the exception-mode and user-mode status bits, and it always records the level-1 cause code. Every vector may be relocated at run time through the vector-base register.

All pins are plain control and state pins; there is no streaming data path. A dispatch is requested by holding `eval_i` high for one cycle with the pending level and the current program counter.

Top module: `irq_dispatch`

## Requirements
- R1: After reset the status word is 0x1F when `HAS_INT`=1 and 0x10 when `HAS_INT`=0, `pc_o` equals `RESET_VEC`, `vb_o` equals `DEF_VECBASE`, and all saved registers, `cause_o` and `taken_o` are zero.
- R2: A request is accepted only when the pending level is greater than the status interrupt-level field (bits 3:0), the level is between 1 and `NUM_LEVELS`, and the AND of that level's mask (slice `(L-1)*IRQ_W` of `lvl_mask_i`), `int_set_i` and `int_en_i` is nonzero.
- R3: A rejected request loads `pc_o` with `pc_i` and leaves the status word, the cause and all saved registers unchanged; with no request and no write the status word and cause stay stable.
- R4: Accepting level L >= 2 writes `pc_i` into saved-PC slot L (slice `(L-1)*AW` of `epc_o`) and the old status word into saved-status slot L (slice `(L-2)*8` of `eps_o`).
- R5: Accepting level L >= 2 sets status bits 3:0 to L and bit 4 (exception mode) to 1, keeps bits 7:5, and loads `pc_o` with the level vector `DEF_VECBASE + LVL_OFS0 + (L-2)*LVL_STRIDE` before relocation.
- R6: Accepting level 1 writes `L1_CAUSE` (default 4) into `cause_o`.
- R7: Accepting level 1 while status bit 4 is set is a double fault: `pc_i` goes to `depc_o` when `HAS_DEPC`=1, else to saved-PC slot 1; `pc_o` gets `DEF_VECBASE + DOUBLE_OFS`; the status word is unchanged.
- R8: Accepting level 1 while status bit 4 is clear writes `pc_i` to saved-PC slot 1, sets status bit 4, and loads `pc_o` with `DEF_VECBASE + USER_OFS` when status bit 5 (user mode) is set, else `DEF_VECBASE + KERNEL_OFS`.
- R9: When `RELOC_EN`=1 every vector is turned into `vector - DEF_VECBASE + vb_o`; when `RELOC_EN`=0 the default vector is used as is.
- R10: `taken_o` is high for exactly the one cycle after the edge that accepted a request and low otherwise.
- R11: `stat_we_i` loads `stat_wd_i` into the status word and `vb_we_i` loads `vb_wd_i` into the vector base on the next edge; in a cycle where a request is accepted the dispatch update of the status word wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eval_i | input | 1 | Dispatch request for this cycle |
| pend_lvl_i | input | 4 | Pending interrupt level |
| lvl_mask_i | input | NUM_LEVELS*IRQ_W | Per-level line masks, level L at slice (L-1)*IRQ_W |
| int_set_i | input | IRQ_W | Raised interrupt lines |
| int_en_i | input | IRQ_W | Enabled interrupt lines |
| pc_i | input | AW | Program counter of the interrupted instruction |
| stat_we_i | input | 1 | Status word write enable |
| stat_wd_i | input | 8 | Status word write data |
| vb_we_i | input | 1 | Vector base write enable |
| vb_wd_i | input | AW | Vector base write data |
| ps_o | output | 8 | Status word: bits 3:0 level, 4 exception mode, 5 user mode |
| epc_o | output | NUM_LEVELS*AW | Saved program counters, level 1 up |
| eps_o | output | (NUM_LEVELS-1)*8 | Saved status words, level 2 up |
| depc_o | output | AW | Double-fault saved program counter |
| cause_o | output | 6 | Exception cause |
| pc_o | output | AW | Next program counter |
| vb_o | output | AW | Vector base register |
| taken_o | output | 1 | One-cycle pulse after an accepted request |

## Verification
A wrong status word shows at once in `ps_o` and, through the interrupt-level comparison, in whether the next request is accepted or refused, so it is visible within the one cycle after the faulty edge and again on the following request. A saved register written into the wrong slot or missed appears on `epc_o`, `eps_o` or `depc_o` in the same cycle as `taken_o`, and a bad vector base shows as a shifted `pc_o` on the next accepted request. The bench therefore sweeps every level against every interrupt level, both mode bits and four line patterns, and compares all state outputs after each request.

// File: rtl/irqd_pkg.sv
`timescale 1ns/1ps
package irqd_pkg;
  localparam int PS_W     = 8;
  localparam int LVL_W    = 4;
  localparam int EXCM_BIT = 4;
  localparam int UM_BIT   = 5;
  localparam int CAUSE_W  = 6;

  typedef enum logic [1:0] {
    K_HIGH   = 2'd0,
    K_USER   = 2'd1,
    K_KERNEL = 2'd2,
    K_DOUBLE = 2'd3
  } take_kind_e;
endpackage

// File: rtl/irqd_gate.sv
`timescale 1ns/1ps
module irqd_gate
  import irqd_pkg::*;
#(
  parameter int NUM_LEVELS = 6,
  parameter int IRQ_W      = 8
) (
  input  logic [LVL_W-1:0]            pend_lvl_i,
  input  logic [LVL_W-1:0]            cur_il_i,
  input  logic                        excm_i,
  input  logic                        um_i,
  input  logic [NUM_LEVELS*IRQ_W-1:0] lvl_mask_i,
  input  logic [IRQ_W-1:0]            int_set_i,
  input  logic [IRQ_W-1:0]            int_en_i,
  output logic                        take_o,
  output take_kind_e                  kind_o
);
  logic [IRQ_W-1:0] sel_mask;
  logic             in_range;
  logic             above;

  always_comb begin
    sel_mask = '0;
    for (int l = 1; l <= NUM_LEVELS; l++) begin
      if (pend_lvl_i == LVL_W'(l)) sel_mask = lvl_mask_i[(l-1)*IRQ_W +: IRQ_W];
    end
  end

  assign in_range = (pend_lvl_i != '0) && (int'(pend_lvl_i) <= NUM_LEVELS);
  assign above    = pend_lvl_i > cur_il_i;
  assign take_o   = above && in_range && (|(sel_mask & int_set_i & int_en_i));

  always_comb begin
    if (pend_lvl_i >= LVL_W'(2)) kind_o = K_HIGH;
    else if (excm_i)             kind_o = K_DOUBLE;
    else if (um_i)               kind_o = K_USER;
    else                         kind_o = K_KERNEL;
  end
endmodule

// File: rtl/irqd_vecsel.sv
`timescale 1ns/1ps
module irqd_vecsel
  import irqd_pkg::*;
#(
  parameter int              AW          = 32,
  parameter bit              RELOC_EN    = 1'b1,
  parameter logic [AW-1:0]   DEF_VECBASE = 32'h4000_0000,
  parameter logic [AW-1:0]   KERNEL_OFS  = 32'h0000_0300,
  parameter logic [AW-1:0]   USER_OFS    = 32'h0000_0340,
  parameter logic [AW-1:0]   DOUBLE_OFS  = 32'h0000_03C0,
  parameter logic [AW-1:0]   LVL_OFS0    = 32'h0000_0180,
  parameter logic [AW-1:0]   LVL_STRIDE  = 32'h0000_0040
) (
  input  take_kind_e       kind_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [AW-1:0]    vb_i,
  output logic [AW-1:0]    vec_o
);
  logic [AW-1:0] lvl_idx;
  logic [AW-1:0] ofs;
  logic [AW-1:0] dflt;

  always_comb begin
    lvl_idx = AW'(lvl_i) - AW'(2);
    case (kind_i)
      K_HIGH:   ofs = LVL_OFS0 + lvl_idx * LVL_STRIDE;
      K_USER:   ofs = USER_OFS;
      K_KERNEL: ofs = KERNEL_OFS;
      default:  ofs = DOUBLE_OFS;
    endcase
    dflt = DEF_VECBASE + ofs;
  end

  generate
    if (RELOC_EN) begin : g_reloc
      assign vec_o = dflt - DEF_VECBASE + vb_i;
    end else begin : g_fixed
      assign vec_o = dflt;
    end
  endgenerate
endmodule

// File: rtl/irqd_regs.sv
`timescale 1ns/1ps
module irqd_regs
  import irqd_pkg::*;
#(
  parameter int            NUM_LEVELS  = 6,
  parameter int            AW          = 32,
  parameter bit            HAS_DEPC    = 1'b1,
  parameter bit            HAS_INT     = 1'b1,
  parameter logic [AW-1:0] DEF_VECBASE = 32'h4000_0000,
  parameter logic [AW-1:0] RESET_VEC   = 32'h5000_0000,
  parameter logic [CAUSE_W-1:0] L1_CAUSE = 6'd4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         eval_i,
  input  logic                         take_i,
  input  take_kind_e                   kind_i,
  input  logic [LVL_W-1:0]             lvl_i,
  input  logic [AW-1:0]                vec_i,
  input  logic [AW-1:0]                pc_i,
  input  logic                         stat_we_i,
  input  logic [PS_W-1:0]              stat_wd_i,
  input  logic                         vb_we_i,
  input  logic [AW-1:0]                vb_wd_i,
  output logic [PS_W-1:0]              ps_o,
  output logic [NUM_LEVELS*AW-1:0]     epc_o,
  output logic [(NUM_LEVELS-1)*PS_W-1:0] eps_o,
  output logic [AW-1:0]                depc_o,
  output logic [CAUSE_W-1:0]           cause_o,
  output logic [AW-1:0]                pc_o,
  output logic [AW-1:0]                vb_o,
  output logic                         taken_o
);
  localparam logic [PS_W-1:0] PS_RST = HAS_INT ? 8'h1F : 8'h10;

  logic [PS_W-1:0]    ps_q;
  logic [AW-1:0]      epc_q [1:NUM_LEVELS];
  logic [PS_W-1:0]    eps_q [2:NUM_LEVELS];
  logic [AW-1:0]      depc_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [AW-1:0]      pc_q;
  logic [AW-1:0]      vb_q;
  logic               taken_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q    <= PS_RST;
      depc_q  <= '0;
      cause_q <= '0;
      pc_q    <= RESET_VEC;
      vb_q    <= DEF_VECBASE;
      taken_q <= 1'b0;
      for (int l = 1; l <= NUM_LEVELS; l++) epc_q[l] <= '0;
      for (int l = 2; l <= NUM_LEVELS; l++) eps_q[l] <= '0;
    end else begin
      taken_q <= 1'b0;
      if (vb_we_i)   vb_q <= vb_wd_i;
      if (stat_we_i) ps_q <= stat_wd_i;
      if (eval_i) begin
        if (take_i) begin
          taken_q <= 1'b1;
          pc_q    <= vec_i;
          if (kind_i == K_HIGH) begin
            for (int l = 2; l <= NUM_LEVELS; l++) begin
              if (lvl_i == LVL_W'(l)) begin
                epc_q[l] <= pc_i;
                eps_q[l] <= ps_q;
              end
            end
            ps_q <= {ps_q[PS_W-1:EXCM_BIT+1], 1'b1, lvl_i};
          end else begin
            cause_q <= L1_CAUSE;
            ps_q    <= ps_q | (PS_W'(1) << EXCM_BIT);
            if (kind_i == K_DOUBLE && HAS_DEPC) depc_q   <= pc_i;
            else                                epc_q[1] <= pc_i;
          end
        end else begin
          pc_q <= pc_i;
        end
      end
    end
  end

  generate
    for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_epc
      assign epc_o[(l-1)*AW +: AW] = epc_q[l];
    end
    for (genvar l = 2; l <= NUM_LEVELS; l++) begin : g_eps
      assign eps_o[(l-2)*PS_W +: PS_W] = eps_q[l];
    end
  endgenerate

  assign ps_o    = ps_q;
  assign depc_o  = depc_q;
  assign cause_o = cause_q;
  assign pc_o    = pc_q;
  assign vb_o    = vb_q;
  assign taken_o = taken_q;

  AST_HI_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && take_i && kind_i == K_HIGH) |=>
      (ps_q[LVL_W-1:0] == $past(lvl_i) && ps_q[EXCM_BIT])); // R5
  AST_L1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && take_i && kind_i != K_HIGH) |=> (cause_q == L1_CAUSE)); // R6
  AST_TAKEN_EXCM: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q |-> ps_q[EXCM_BIT]); // R8
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_i && !stat_we_i) |=> ($stable(ps_q) && $stable(cause_q))); // R3
  AST_DOUBLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && take_i && kind_i == K_DOUBLE && !stat_we_i) |=> $stable(ps_q)); // R7
endmodule

// File: rtl/irq_dispatch.sv
`timescale 1ns/1ps
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int            NUM_LEVELS  = 6,
  parameter int            IRQ_W       = 8,
  parameter int            AW          = 32,
  parameter bit            HAS_DEPC    = 1'b1,
  parameter bit            HAS_INT     = 1'b1,
  parameter bit            RELOC_EN    = 1'b1,
  parameter logic [AW-1:0] DEF_VECBASE = 32'h4000_0000,
  parameter logic [AW-1:0] RESET_VEC   = 32'h5000_0000,
  parameter logic [AW-1:0] KERNEL_OFS  = 32'h0000_0300,
  parameter logic [AW-1:0] USER_OFS    = 32'h0000_0340,
  parameter logic [AW-1:0] DOUBLE_OFS  = 32'h0000_03C0,
  parameter logic [AW-1:0] LVL_OFS0    = 32'h0000_0180,
  parameter logic [AW-1:0] LVL_STRIDE  = 32'h0000_0040,
  parameter logic [5:0]    L1_CAUSE    = 6'd4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            eval_i,
  input  logic [3:0]                      pend_lvl_i,
  input  logic [NUM_LEVELS*IRQ_W-1:0]     lvl_mask_i,
  input  logic [IRQ_W-1:0]                int_set_i,
  input  logic [IRQ_W-1:0]                int_en_i,
  input  logic [AW-1:0]                   pc_i,
  input  logic                            stat_we_i,
  input  logic [7:0]                      stat_wd_i,
  input  logic                            vb_we_i,
  input  logic [AW-1:0]                   vb_wd_i,
  output logic [7:0]                      ps_o,
  output logic [NUM_LEVELS*AW-1:0]        epc_o,
  output logic [(NUM_LEVELS-1)*8-1:0]     eps_o,
  output logic [AW-1:0]                   depc_o,
  output logic [5:0]                      cause_o,
  output logic [AW-1:0]                   pc_o,
  output logic [AW-1:0]                   vb_o,
  output logic                            taken_o
);
  logic          take;
  take_kind_e    kind;
  logic [AW-1:0] vec;

  irqd_gate #(.NUM_LEVELS(NUM_LEVELS), .IRQ_W(IRQ_W)) u_gate (
    .pend_lvl_i (pend_lvl_i),
    .cur_il_i   (ps_o[LVL_W-1:0]),
    .excm_i     (ps_o[EXCM_BIT]),
    .um_i       (ps_o[UM_BIT]),
    .lvl_mask_i (lvl_mask_i),
    .int_set_i  (int_set_i),
    .int_en_i   (int_en_i),
    .take_o     (take),
    .kind_o     (kind)
  );

  irqd_vecsel #(
    .AW(AW), .RELOC_EN(RELOC_EN), .DEF_VECBASE(DEF_VECBASE),
    .KERNEL_OFS(KERNEL_OFS), .USER_OFS(USER_OFS), .DOUBLE_OFS(DOUBLE_OFS),
    .LVL_OFS0(LVL_OFS0), .LVL_STRIDE(LVL_STRIDE)
  ) u_vecsel (
    .kind_i (kind),
    .lvl_i  (pend_lvl_i),
    .vb_i   (vb_o),
    .vec_o  (vec)
  );

  irqd_regs #(
    .NUM_LEVELS(NUM_LEVELS), .AW(AW), .HAS_DEPC(HAS_DEPC), .HAS_INT(HAS_INT),
    .DEF_VECBASE(DEF_VECBASE), .RESET_VEC(RESET_VEC), .L1_CAUSE(L1_CAUSE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval_i    (eval_i),
    .take_i    (take),
    .kind_i    (kind),
    .lvl_i     (pend_lvl_i),
    .vec_i     (vec),
    .pc_i      (pc_i),
    .stat_we_i (stat_we_i),
    .stat_wd_i (stat_wd_i),
    .vb_we_i   (vb_we_i),
    .vb_wd_i   (vb_wd_i),
    .ps_o      (ps_o),
    .epc_o     (epc_o),
    .eps_o     (eps_o),
    .depc_o    (depc_o),
    .cause_o   (cause_o),
    .pc_o      (pc_o),
    .vb_o      (vb_o),
    .taken_o   (taken_o)
  );

  AST_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && pend_lvl_i <= ps_o[LVL_W-1:0]) |=> !taken_o); // R2
  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && int'(pend_lvl_i) > NUM_LEVELS) |=> !taken_o); // R2
  AST_NO_REQ_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> !taken_o); // R10
endmodule

// File: tb/irq_dispatch_bench.sv
`timescale 1ns/1ps
module irq_dispatch_bench;
  localparam int NL = 6;
  localparam int IW = 8;
  localparam logic [31:0] DEFVB = 32'h4000_0000;
  localparam logic [31:0] RSTV  = 32'h5000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eval_i = 1'b0;
  logic [3:0] pend_lvl_i = '0;
  logic [NL*IW-1:0] lvl_mask_i;
  logic [IW-1:0] int_set_i = '0, int_en_i = '0;
  logic [31:0] pc_i = '0;
  logic stat_we_i = 1'b0;
  logic [7:0] stat_wd_i = '0;
  logic vb_we_i = 1'b0;
  logic [31:0] vb_wd_i = '0;

  logic [7:0] ps_o, a_ps;
  logic [NL*32-1:0] epc_o, a_epc;
  logic [(NL-1)*8-1:0] eps_o, a_eps;
  logic [31:0] depc_o, pc_o, vb_o, a_depc, a_pc, a_vb;
  logic [5:0] cause_o, a_cause;
  logic taken_o, a_taken;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  generate
    for (genvar l = 1; l <= NL; l++) begin : g_m
      assign lvl_mask_i[(l-1)*IW +: IW] = IW'(1) << (l-1);
    end
  endgenerate

  irq_dispatch u_irq_dispatch (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .pend_lvl_i(pend_lvl_i),
    .lvl_mask_i(lvl_mask_i), .int_set_i(int_set_i), .int_en_i(int_en_i),
    .pc_i(pc_i), .stat_we_i(stat_we_i), .stat_wd_i(stat_wd_i),
    .vb_we_i(vb_we_i), .vb_wd_i(vb_wd_i), .ps_o(ps_o), .epc_o(epc_o),
    .eps_o(eps_o), .depc_o(depc_o), .cause_o(cause_o), .pc_o(pc_o),
    .vb_o(vb_o), .taken_o(taken_o));

  irq_dispatch #(.HAS_DEPC(1'b0), .HAS_INT(1'b0), .RELOC_EN(1'b0)) u_alt (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .pend_lvl_i(pend_lvl_i),
    .lvl_mask_i(lvl_mask_i), .int_set_i(int_set_i), .int_en_i(int_en_i),
    .pc_i(pc_i), .stat_we_i(stat_we_i), .stat_wd_i(stat_wd_i),
    .vb_we_i(vb_we_i), .vb_wd_i(vb_wd_i), .ps_o(a_ps), .epc_o(a_epc),
    .eps_o(a_eps), .depc_o(a_depc), .cause_o(a_cause), .pc_o(a_pc),
    .vb_o(a_vb), .taken_o(a_taken));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  logic [31:0] m_epc [1:NL];
  logic [7:0]  m_eps [2:NL];
  logic [31:0] m_depc;
  logic [5:0]  m_cause;

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int run = 0;
    for (int l = 1; l <= NL; l++) m_epc[l] = '0;
    for (int l = 2; l <= NL; l++) m_eps[l] = '0;
    m_depc = '0; m_cause = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 ps", 32'(ps_o), 32'h1F);
    chk("R1 alt ps", 32'(a_ps), 32'h10);
    chk("R1 pc", pc_o, RSTV);
    chk("R1 vb", vb_o, DEFVB);
    chk("R1 cause", 32'(cause_o), 0);
    chk("R1 taken", 32'(taken_o), 0);
    chk("R1 epc1", epc_o[31:0], 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hold after release", pc_o, RSTV);

    for (int lvl = 0; lvl < 8; lvl++)
      for (int il = 0; il < 8; il++)
        for (int ex = 0; ex < 2; ex++)
          for (int um = 0; um < 2; um++)
            for (int pat = 0; pat < 4; pat++) begin
              logic [7:0] ps_w, exp_ps, mk;
              logic [31:0] vb, pc, exp_pc, alt_pc, ofs;
              bit tk;
              run++;
              vb = 32'h2000_0000 + (32'(run) << 12);
              pc = 32'h1000_0000 + 32'(run) * 4;
              ps_w = {2'b00, 1'(um), 1'(ex), 4'(il)};
              mk = (lvl >= 1 && lvl <= NL) ? (8'h1 << (lvl - 1)) : 8'h0;
              // write status and vector base (R11)
              @(negedge clk);
              chk("R10 pulse ends", 32'(taken_o), 0);
              stat_we_i = 1'b1; stat_wd_i = ps_w;
              vb_we_i = 1'b1; vb_wd_i = vb;
              @(negedge clk);
              stat_we_i = 1'b0; vb_we_i = 1'b0;
              chk("R11 ps write", 32'(ps_o), 32'(ps_w));
              chk("R11 vb write", vb_o, vb);
              case (pat)
                0: begin int_set_i = 8'hFF; int_en_i = 8'hFF; end
                1: begin int_set_i = 8'hFF; int_en_i = 8'h00; end
                2: begin int_set_i = 8'hFF; int_en_i = ~mk; end
                default: begin int_set_i = ~mk; int_en_i = 8'hFF; end
              endcase
              eval_i = 1'b1; pend_lvl_i = 4'(lvl); pc_i = pc;
              @(negedge clk);
              eval_i = 1'b0;
              tk = (lvl > il) && (lvl >= 1) && (lvl <= NL) && (pat == 0);
              exp_ps = ps_w;
              exp_pc = pc; alt_pc = pc;
              if (tk) begin
                if (lvl >= 2) begin
                  m_epc[lvl] = pc; m_eps[lvl] = ps_w;
                  exp_ps = {ps_w[7:5], 1'b1, 4'(lvl)};
                  ofs = 32'h180 + 32'(lvl - 2) * 32'h40;
                end else begin
                  m_cause = 6'd4;
                  if (ex == 1) begin
                    m_depc = pc; ofs = 32'h3C0;
                  end else begin
                    m_epc[1] = pc; exp_ps = ps_w | 8'h10;
                    ofs = (um == 1) ? 32'h340 : 32'h300;
                  end
                end
                exp_pc = vb + ofs;
                alt_pc = DEFVB + ofs;
              end
              chk("R2 R10 taken", 32'(taken_o), 32'(tk));
              chk("R9 R3 pc", pc_o, exp_pc);
              chk("R9 alt pc fixed vectors", a_pc, alt_pc);
              chk("R5 R7 R8 ps", 32'(ps_o), 32'(exp_ps));
              chk("R6 cause", 32'(cause_o), 32'(m_cause));
              chk("R7 depc", depc_o, m_depc);
              for (int l = 1; l <= NL; l++)
                chk("R4 R8 epc", epc_o[(l-1)*32 +: 32], m_epc[l]);
              for (int l = 2; l <= NL; l++)
                chk("R4 eps", 32'(eps_o[(l-2)*8 +: 8]), 32'(m_eps[l]));
              if (tk && lvl == 1 && ex == 1)
                chk("R7 alt double to epc1", a_epc[31:0], pc);
            end

    @(negedge clk);
    chk("R7 alt depc unused", a_depc, 0);
    // R3 quiet cycles keep state
    begin
      logic [7:0] ps_keep;
      ps_keep = ps_o;
      repeat (3) @(negedge clk);
      chk("R3 quiet ps", 32'(ps_o), 32'(ps_keep));
      chk("R10 quiet taken", 32'(taken_o), 0);
    end
    // R11 take wins over status write in the same cycle
    @(negedge clk);
    stat_we_i = 1'b1; stat_wd_i = 8'h00;
    @(negedge clk);
    stat_wd_i = 8'hC0;
    eval_i = 1'b1; pend_lvl_i = 4'd3; int_set_i = 8'hFF; int_en_i = 8'hFF; pc_i = 32'h0BAD_0000;
    @(negedge clk);
    stat_we_i = 1'b0; eval_i = 1'b0;
    chk("R11 take wins", 32'(ps_o), 32'h13);
    chk("R4 eps3 pre-take", 32'(eps_o[8 +: 8]), 32'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule